// File: doc/BRIEF.md
# Byte-Serial Peripheral Port (Master/Slave)

This block moves one byte at a time over a four-wire synchronous serial link, sending and receiving at once. It runs either as bus master, making the serial clock and driving a single active-low select, or as slave, following a clock and select that an external master drives. A small register-style host port gives a control register, a status register holding a transfer-done flag and a write-collision flag, and a data register. A data write loads the byte to send. In master mode the same write also starts the transfer. Once the byte is complete, a data read returns the byte received.

In master mode the serial clock comes from the system clock through a power-of-two prescaler. The prescaler is set by two rate bits and a double-speed bit. In slave mode the incoming clock, select and data pass through a two-stage synchronizer. The serial clock must therefore run at no more than a quarter of the system clock. One data pin pair serves both roles: `sd_o` carries the outgoing bit stream and `sd_i` the incoming one, whichever side this block plays.

Top module: `spi_port`

## Requirements
- R1: After reset, control, status and data all read 0, `sclk_o` is 0 and `ss_n_o` is 1.
- R2: Registers by `addr`: 0 control, 1 status, 2 data. Control bits are [0] enable, [1] master, [2] LSB-first, [3] clock idle level (CPOL), [4] phase (CPHA), [6:5] rate, [7] double speed. Control reads back what was written. Status bits are [0] done and [1] collision.
- R3: In master mode the serial clock half-period in system cycles is 2, 8, 32 or 64 for rate 0 to 3, and 1, 4, 16 or 32 with double speed set. With a data write at clock edge T, serial edge k (1..16) occurs at edge T + k·half.
- R4: In master mode `ss_n_o` goes low in the cycle after the starting data write and returns high on the 16th serial edge. `sclk_o` sits at the CPOL level whenever `ss_n_o` is high.
- R5: With LSB-first set, bit 0 goes out and comes in first. Otherwise bit 7 goes first.
- R6: With CPHA 0, data is sampled on odd serial edges and the next bit is driven on even edges, and the first bit is on `sd_o` before edge 1. With CPHA 1, bits are driven on odd edges and sampled on even edges.
- R7: After a master transfer, the data register holds the 8 bits sampled from `sd_i`.
- R8: The done flag sets when the eighth bit is complete.
- R9: A data write while a master transfer runs sets the collision flag and changes neither the bits sent nor the byte received.
- R10: Done and collision clear only when a status read that saw them set is followed by a data read or write. A data access with no status read before it leaves them set.
- R11: In slave mode, with enable set and `ss_n_i` low, the block shifts the preloaded byte out on `sd_o` and takes a byte in from `sd_i` on the edges of `sclk_i`, under the same order and phase rules as master mode, and then sets done.
- R12: In slave mode, `ss_n_i` rising before 16 serial edges abandons the byte without setting done, and the next selection starts again from bit 0.
- R13: In slave mode, a data write while selected sets the collision flag and leaves the data register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Host register write strobe |
| rd_en | input | 1 | Host register read strobe (drives flag clearing) |
| addr | input | 2 | Register select |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, combinational on `addr` |
| sclk_o | output | 1 | Serial clock driven in master mode |
| ss_n_o | output | 1 | Active-low select driven in master mode |
| sclk_i | input | 1 | Serial clock received in slave mode |
| ss_n_i | input | 1 | Active-low select received in slave mode |
| sd_i | input | 1 | Incoming serial data |
| sd_o | output | 1 | Outgoing serial data |

## Verification
A wrong half-period count or edge counter shows up on `sclk_o` or `ss_n_o` within one half-period, because the bench predicts both pins for every cycle of a master transfer. A wrong phase, bit order or shift-register state shows on `sd_o` at the next bit that should have changed, and in the received byte once the transfer ends. Flag faults are visible in the status read that follows each transfer or collision. A slave counter that is not cleared on deselect shows as a wrong received byte or a missing done flag in the transfer that follows the abort.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

    typedef struct packed {
        logic       dbl;
        logic [1:0] rate;
        logic       cpha;
        logic       cpol;
        logic       lsb_first;
        logic       master;
        logic       en;
    } ctrl_t;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_DATA = 2'd2;

    // log2 of the serial half-period in system cycles
    function automatic logic [2:0] half_log2(input logic [1:0] rate, input logic dbl);
        logic [2:0] s;
        s = (rate == 2'd3) ? 3'd6 : {rate, 1'b1};
        return s - {2'b00, dbl};
    endfunction

endpackage

// File: rtl/spi_port_rate.sv
module spi_port_rate
    import spi_port_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] rate,
    input  logic       dbl,
    output logic       tick
);
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] lim;

    always_comb begin
        lim  = CNT_W'((32'd1 << half_log2(rate, dbl)) - 32'd1);
        tick = run && (cnt_q == lim);
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spi_port_sync.sv
module spi_port_sync #(
    parameter int           W       = 3,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
    end

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[g] <= RST_VAL;
            else        stg_q[g] <= stg_d[g];
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/spi_port_shifter.sv
module spi_port_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         do_shift,
    input  logic         shift_in,
    input  logic         lsb_first,
    output logic         out_bit,
    output logic [W-1:0] value
);
    logic [W-1:0] v_d, v_q;

    always_comb begin
        v_d = v_q;
        if (load)           v_d = load_val;
        else if (do_shift)  v_d = lsb_first ? {shift_in, v_q[W-1:1]}
                                            : {v_q[W-2:0], shift_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) v_q <= '0;
        else        v_q <= v_d;
    end

    assign out_bit = lsb_first ? v_q[0] : v_q[W-1];
    assign value   = v_q;
endmodule

// File: rtl/spi_port.sv
module spi_port
    import spi_port_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              sclk_o,
    output logic              ss_n_o,
    input  logic              sclk_i,
    input  logic              ss_n_i,
    input  logic              sd_i,
    output logic              sd_o
);
    localparam int            EDGES = 2 * DATA_W;
    localparam int            EW    = $clog2(EDGES + 1);
    localparam logic [EW-1:0] LAST  = EW'(EDGES);

    typedef struct packed {
        ctrl_t         ctrl;
        logic          busy;
        logic [EW-1:0] edges;
        logic          sclk;
        logic          rx_bit;
        logic          done;
        logic          wcol;
        logic          arm_done;
        logic          arm_wcol;
        logic          sclk_prev;
    } st_t;

    st_t d, q;

    logic              tick;
    logic              s_sclk, s_ss_n, s_sdi;
    logic              load, do_shift, shift_in, out_bit;
    logic [DATA_W-1:0] sh_val;

    // signals exposed to the bound checker
    logic mode_master, cfg_dbl, flag_done, flag_wcol;
    assign mode_master = q.ctrl.master;
    assign cfg_dbl     = q.ctrl.dbl;
    assign flag_done   = q.done;
    assign flag_wcol   = q.wcol;

    spi_port_rate #(.CNT_W(CNT_W)) u_rate (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (q.busy),
        .rate  (q.ctrl.rate),
        .dbl   (q.ctrl.dbl),
        .tick  (tick)
    );

    spi_port_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({sclk_i, ss_n_i, sd_i}),
        .dout  ({s_sclk, s_ss_n, s_sdi})
    );

    spi_port_shifter #(.W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_val  (wdata),
        .do_shift  (do_shift),
        .shift_in  (shift_in),
        .lsb_first (q.ctrl.lsb_first),
        .out_bit   (out_bit),
        .value     (sh_val)
    );

    always_comb begin
        logic          wr_data, rd_data, wr_ctrl, rd_stat;
        logic          running, m_ev, s_ev, ev, sample, sdi;
        logic [EW-1:0] k;

        d        = q;
        load     = 1'b0;
        do_shift = 1'b0;
        shift_in = q.rx_bit;

        wr_data = wr_en && (addr == A_DATA);
        rd_data = rd_en && (addr == A_DATA);
        wr_ctrl = wr_en && (addr == A_CTRL);
        rd_stat = rd_en && (addr == A_STAT);

        // flag clearing: status read arms, data access clears
        if (rd_stat) begin
            d.arm_done = q.done;
            d.arm_wcol = q.wcol;
        end
        if (wr_data || rd_data) begin
            if (q.arm_done) d.done = 1'b0;
            if (q.arm_wcol) d.wcol = 1'b0;
            d.arm_done = 1'b0;
            d.arm_wcol = 1'b0;
        end

        if (wr_ctrl) d.ctrl = ctrl_t'(wdata[7:0]);

        running = q.ctrl.master ? q.busy : (q.ctrl.en && !s_ss_n);

        // serial edge events
        m_ev   = q.ctrl.en && q.ctrl.master && q.busy && tick;
        s_ev   = q.ctrl.en && !q.ctrl.master && !s_ss_n && (s_sclk != q.sclk_prev);
        ev     = m_ev || s_ev;
        k      = q.edges + 1'b1;
        sample = k[0] ^ q.ctrl.cpha;
        sdi    = q.ctrl.master ? sd_i : s_sdi;

        if (ev) begin
            d.edges = k;
            if (m_ev) d.sclk = ~q.sclk;
            if (sample) begin
                d.rx_bit = sdi;
                if (k == LAST) begin
                    do_shift = 1'b1;
                    shift_in = sdi;
                end
            end else if (!(q.ctrl.cpha && k == EW'(1))) begin
                do_shift = 1'b1;
            end
            if (k == LAST) begin
                d.edges = '0;
                d.done  = 1'b1;
                d.busy  = 1'b0;
            end
        end

        d.sclk_prev = s_sclk;
        if (!q.ctrl.master && s_ss_n) d.edges = '0;

        // data write: load or collide
        if (wr_data) begin
            if (running) begin
                d.wcol = 1'b1;
            end else begin
                load = 1'b1;
                if (q.ctrl.en && q.ctrl.master) begin
                    d.busy  = 1'b1;
                    d.edges = '0;
                    d.sclk  = q.ctrl.cpol;
                end
            end
        end

        if (!q.ctrl.en) begin
            d.busy  = 1'b0;
            d.edges = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (addr)
            A_CTRL:  rdata = DATA_W'(q.ctrl);
            A_STAT:  rdata = DATA_W'({q.wcol, q.done});
            A_DATA:  rdata = sh_val;
            default: rdata = '0;
        endcase
    end

    assign sclk_o = q.busy ? q.sclk : q.ctrl.cpol;
    assign ss_n_o = !q.busy;
    assign sd_o   = out_bit;
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk
    import spi_port_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       rd_en,
    input logic [1:0] addr,
    input logic       sclk_o,
    input logic       ss_n_o,
    input logic       mode_master,
    input logic       cfg_dbl,
    input logic       flag_done,
    input logic       flag_wcol
);
    // R3: without double speed a serial edge is never followed by another one cycle later
    p_half_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_master && !ss_n_o && !cfg_dbl && (sclk_o != $past(sclk_o)))
        |=> (sclk_o == $past(sclk_o)));

    // R4: select falls only after a data write
    p_sel_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_master && $fell(ss_n_o)) |-> $past(wr_en && addr == A_DATA));

    // R8: in master mode done rises together with the select release
    p_done_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_master && $rose(flag_done)) |-> $rose(ss_n_o));

    // R9: collision only comes from a data write
    p_wcol_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_wcol) |-> $past(wr_en && addr == A_DATA));

    // R10: flags drop only after a data access
    p_done_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_done) |-> $past((wr_en || rd_en) && addr == A_DATA));

    p_wcol_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_wcol) |-> $past((wr_en || rd_en) && addr == A_DATA));
endmodule

bind spi_port spi_port_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .addr        (addr),
    .sclk_o      (sclk_o),
    .ss_n_o      (ss_n_o),
    .mode_master (mode_master),
    .cfg_dbl     (cfg_dbl),
    .flag_done   (flag_done),
    .flag_wcol   (flag_wcol)
);

// File: tb/spi_port_tb.sv
module spi_port_tb;
    localparam logic [1:0] RA_CTRL = 2'd0, RA_STAT = 2'd1, RA_DATA = 2'd2;
    localparam int HS = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en, rd_en;
    logic [1:0] addr;
    logic [7:0] wdata;
    wire  [7:0] rdata;
    wire        sclk_o, ss_n_o, sd_o;
    logic       sclk_i, ss_n_i, sd_i;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    spi_port u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .sclk_o(sclk_o), .ss_n_o(ss_n_o),
        .sclk_i(sclk_i), .ss_n_i(ss_n_i), .sd_i(sd_i), .sd_o(sd_o)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    function automatic logic [7:0] mk_ctrl(input logic en, master, lsb, cpol, cpha,
                                           input logic [1:0] rate, input logic dbl);
        return {dbl, rate, cpha, cpol, lsb, master, en};
    endfunction

    function automatic int half_of(input logic [1:0] rate, input logic dbl);
        int div;
        case (rate)
            2'd0: div = 4;
            2'd1: div = 16;
            2'd2: div = 64;
            default: div = 128;
        endcase
        if (dbl) div = div / 2;
        return div / 2;
    endfunction

    function automatic logic pick(input logic [7:0] b, input int i, input logic lsb);
        return lsb ? b[i] : b[7-i];
    endfunction

    function automatic int bit_idx(input int e, input logic cpha);
        if (!cpha) return e / 2;
        return (e == 0) ? 0 : (e - 1) / 2;
    endfunction

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic run_master(input logic [1:0] rate, input logic dbl, cpol, cpha, lsb,
                              input logic [7:0] tx, slv, input bit collide);
        int h;
        logic [7:0] v;
        h = half_of(rate, dbl);
        bus_wr(RA_CTRL, mk_ctrl(1'b1, 1'b1, lsb, cpol, cpha, rate, dbl));
        bus_wr(RA_DATA, tx);
        for (int j = 0; j <= 16 * h + 2; j++) begin
            int e;
            int ix;
            logic [2:0] expv;
            e = j / h;
            if (e < 16) begin
                ix = bit_idx(e, cpha);
                sd_i = pick(slv, ix, lsb);
                expv = {1'b0, cpol ^ (e % 2 == 1), pick(tx, ix, lsb)};
            end else begin
                expv = {1'b1, cpol, pick(slv, 0, lsb)};
            end
            if (collide && j == 3) begin
                wr_en = 1'b1; addr = RA_DATA; wdata = ~tx;
            end else begin
                wr_en = 1'b0;
            end
            #1 chk("R3 R4 R5 R6 master pins {ss_n,sclk,sd_o}", {29'd0, ss_n_o, sclk_o, sd_o}, {29'd0, expv});
            @(negedge clk);
        end
        wr_en = 1'b0;
        bus_rd(RA_DATA, v);
        chk("R7 R9 master received byte", v, slv);
        bus_rd(RA_STAT, v);
        chk("R8 R9 R10 status after transfer, flags kept by unarmed data read", v, collide ? 8'h03 : 8'h01);
        bus_rd(RA_DATA, v);
        bus_rd(RA_STAT, v);
        chk("R10 status cleared after status then data read", v, 8'h00);
    endtask

    task automatic run_slave(input logic cpol, cpha, lsb, input logic [7:0] stx, mtx,
                             input int abort_at);
        int bi;
        int si;
        logic [7:0] v;
        bus_wr(RA_CTRL, mk_ctrl(1'b1, 1'b0, lsb, cpol, cpha, 2'd0, 1'b0));
        sclk_i = cpol;
        repeat (4) @(negedge clk);
        bus_wr(RA_DATA, stx);
        bi = 0;
        si = 0;
        ss_n_i = 1'b0;
        if (!cpha) begin
            sd_i = pick(mtx, 0, lsb);
            bi = 1;
        end
        for (int e = 1; e <= 16; e++) begin
            repeat (HS) @(negedge clk);
            if (e == abort_at) break;
            if (((e % 2) == 1) != cpha) begin
                chk("R11 slave sd_o bit", {31'd0, sd_o}, {31'd0, pick(stx, si, lsb)});
                si++;
                sclk_i = ~sclk_i;
            end else begin
                sclk_i = ~sclk_i;
                if (bi < 8) begin
                    sd_i = pick(mtx, bi, lsb);
                    bi++;
                end
            end
        end
        repeat (HS) @(negedge clk);
        ss_n_i = 1'b1;
        sclk_i = cpol;
        repeat (6) @(negedge clk);
        if (abort_at > 0) begin
            bus_rd(RA_STAT, v);
            chk("R12 no done after mid-byte deselect", v, 8'h00);
        end else begin
            bus_rd(RA_STAT, v);
            chk("R11 slave done flag", v, 8'h01);
            bus_rd(RA_DATA, v);
            chk("R11 slave received byte", v, mtx);
            bus_rd(RA_STAT, v);
            chk("R10 slave flags cleared", v, 8'h00);
        end
    endtask

    initial begin
        logic [7:0] v;
        wr_en = 1'b0; rd_en = 1'b0; addr = 2'd0; wdata = 8'h00;
        sclk_i = 1'b0; ss_n_i = 1'b1; sd_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 sclk_o after reset", {31'd0, sclk_o}, 32'd0);
        chk("R1 ss_n_o after reset", {31'd0, ss_n_o}, 32'd1);
        bus_rd(RA_CTRL, v); chk("R1 control after reset", v, 8'h00);
        bus_rd(RA_STAT, v); chk("R1 status after reset", v, 8'h00);
        bus_rd(RA_DATA, v); chk("R1 data after reset", v, 8'h00);

        // R2 control readback
        bus_wr(RA_CTRL, 8'hA5);
        bus_rd(RA_CTRL, v); chk("R2 control readback", v, 8'hA5);
        bus_wr(RA_CTRL, 8'h00);

        // master transfers across rates, phases, polarities, orders
        run_master(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 8'h3C, 1'b0);
        run_master(2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 8'h96, 8'hE1, 1'b0);
        run_master(2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h81, 8'h7E, 1'b0);
        run_master(2'd3, 1'b0, 1'b1, 1'b0, 1'b1, 8'h4D, 8'hB2, 1'b0);
        run_master(2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 8'h0F, 8'hF0, 1'b0);
        run_master(2'd3, 1'b1, 1'b1, 1'b1, 1'b0, 8'h5A, 8'hC3, 1'b0);
        // R9 collision during a running master transfer
        run_master(2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h69, 8'h17, 1'b1);

        // slave transfers
        run_slave(1'b0, 1'b0, 1'b0, 8'hC6, 8'h5B, 0);
        run_slave(1'b1, 1'b1, 1'b1, 8'h39, 8'hA4, 0);
        run_slave(1'b0, 1'b1, 1'b0, 8'h72, 8'h8D, 0);
        // R12 abort then a clean transfer
        run_slave(1'b1, 1'b0, 1'b1, 8'hFF, 8'h00, 6);
        run_slave(1'b1, 1'b0, 1'b1, 8'h2B, 8'hD4, 0);

        // R13 slave collision while selected
        bus_wr(RA_DATA, 8'h3C);
        ss_n_i = 1'b0;
        repeat (5) @(negedge clk);
        bus_wr(RA_DATA, 8'hC3);
        ss_n_i = 1'b1;
        repeat (5) @(negedge clk);
        bus_rd(RA_STAT, v); chk("R13 slave collision flag", v, 8'h02);
        bus_rd(RA_DATA, v); chk("R13 data register kept", v, 8'h3C);
        bus_rd(RA_STAT, v); chk("R10 collision cleared", v, 8'h00);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual hung, expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule